// File: doc/BRIEF.md
# Serial Receiver Reset Sequencer

This block drives the digital reset and the clock-recovery mode controls of one serial transceiver receive channel. It runs on the channel's parallel clock. It takes four status flags: transmit PLL locked, signal present, frequency locked and a FIFO/data error strobe from user logic. Each flag may arrive from another clock domain, so each passes through a two-flop synchroniser before the control logic sees it.

A static mode input picks one of two modes. In manual mode the controller first holds the recovery circuit on the reference clock for a programmed number of cycles. It then moves the circuit onto the incoming data in a single cycle, waits a second programmed interval and releases the digital reset. In automatic mode the recovery circuit picks its own lock source, so both lock controls stay low. The controller keeps the digital reset asserted until frequency lock has stayed high for a programmed run of consecutive cycles, and asserts it again whenever lock drops.

A loss of PLL lock or a loss of signal sends the controller back to its initial state, and the sequence starts again once both are present. A reported FIFO or data error causes a fixed two-cycle reset pulse.

Top module: `rx_reset_seq`

## Requirements
- R1: While `rst_n` is low and in the cycle after, `rx_digital_rst_o` is 1, `lock_data_o` is 0 and `ready_o` is 0. `lock_ref_o` is 1 in manual mode (`auto_mode_i`=0) and 0 in automatic mode (`auto_mode_i`=1).
- R2: Every status input acts on the control logic through exactly two register stages. A change driven before clock edge k takes effect on the outputs after edge k+2, or after edge k+3 where the state machine adds a step.
- R3: In manual mode, once both PLL lock and signal present are seen, `lock_ref_o` stays high for a further LTR_CYCLES cycles. `lock_ref_o` then falls and `lock_data_o` rises on the same edge. The two are never high together.
- R4: In manual mode, `rx_digital_rst_o` falls exactly LTD_CYCLES cycles after `lock_data_o` rises, and `lock_data_o` is high when it falls.
- R5: When the synchronised PLL lock is low, the next cycle shows the initial state (reset high, lock-to-data low, lock-to-reference high in manual mode). All wait counts restart, and the sequence proceeds only after PLL lock returns.
- R6: A low synchronised signal-present flag has the same effect as R5. Its return restarts the sequence.
- R7: In automatic mode both lock controls stay 0. In the cycle after the synchronised frequency lock is seen low, `rx_digital_rst_o` is 1.
- R8: In automatic mode the reset is released only after frequency lock has been high for STABLE_CYCLES consecutive synchronised cycles. Any low cycle restarts that count, even after release.
- R9: A high synchronised error flag while the reset is released drives `rx_digital_rst_o` high for exactly 2 cycles, after which it is released again (in automatic mode only if frequency lock is high). Error flags seen while the reset is already asserted have no effect.
- R10: `ready_o` is 1 only when the digital reset is released and the synchronised PLL lock and signal present (and frequency lock, in automatic mode) are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock of the channel |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_mode_i | input | 1 | 1 = automatic lock mode, 0 = manual; static outside reset |
| pll_locked_i | input | 1 | Transmit PLL lock status, asynchronous |
| sig_det_i | input | 1 | Receive signal present, asynchronous |
| freq_lock_i | input | 1 | Recovery circuit frequency lock, asynchronous |
| fifo_err_i | input | 1 | Data corruption / FIFO overflow or underflow from user logic |
| rx_digital_rst_o | output | 1 | Receiver digital reset, active high |
| lock_ref_o | output | 1 | Force recovery circuit onto the reference clock |
| lock_data_o | output | 1 | Force recovery circuit onto the received data |
| ready_o | output | 1 | Channel ready for traffic |

## Verification
The bench builds the block with LTR_CYCLES=6, LTD_CYCLES=4 and STABLE_CYCLES=5. With these values a complete manual bring-up takes about a dozen cycles, so restarts after loss of PLL lock or loss of signal can be run many times in a short run. The short stable window lets the bench drop frequency lock one cycle before the count completes, and check that release is held back. An error pulse lands well clear of the interval boundaries, so its two-cycle width can be measured on its own.

// File: rtl/rxrs_pkg.sv
// Shared types for the receiver reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rxrs_pkg;

    // Controller phases
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // waiting for PLL lock and signal
        ST_LTR   = 3'd1,   // manual: held on reference
        ST_LTD   = 3'd2,   // manual: on data, reset still held
        ST_RUN   = 3'd3,   // reset released
        ST_AWAIT = 3'd4,   // automatic: counting stable frequency lock
        ST_PULSE = 3'd5    // fixed error reset pulse
    } rxrs_state_e;

    // Width of the error reset pulse in parallel clock cycles
    localparam int PULSE_LEN = 2;

    // Number of status flags passed through the synchroniser
    localparam int N_STATUS = 4;

endpackage

// File: rtl/rxrs_sync.sv
// Multi-stage flop synchroniser for a vector of quasi-static status flags.
// Assumes: each bit is independent; a reset value of 0 means "condition absent".
module rxrs_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);

    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= din_i;
                end
            end else begin : g_next
                // Shift one stage further
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= '0;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign dout_o = stg[STAGES-1];

endmodule

// File: rtl/rxrs_timer.sv
// Interval counter: counts cycles while run_i is high and clears when it is low.
// done_o is high in the LIMIT-th consecutive cycle of run_i.
// Assumes: LIMIT >= 1; the owner drops run_i soon after done_o.
module rxrs_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);

    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Count while running, hold at the last value, clear when idle
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!run_i)  cnt <= '0;
        else if (!done_o) cnt <= cnt + 1'b1;
    end

    assign done_o = run_i && (cnt == LAST);

endmodule

// File: rtl/rx_reset_seq.sv
// Receiver reset sequencer top. Synchronises the status flags and runs the
// manual or automatic lock sequence, loss-of-link restarts and error pulses.
// Assumes: auto_mode_i changes only while rst_n is low; all intervals >= 1.
module rx_reset_seq
    import rxrs_pkg::*;
#(
    parameter int LTR_CYCLES    = 5000,
    parameter int LTD_CYCLES    = 4000,
    parameter int STABLE_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_mode_i,
    input  logic pll_locked_i,
    input  logic sig_det_i,
    input  logic freq_lock_i,
    input  logic fifo_err_i,
    output logic rx_digital_rst_o,
    output logic lock_ref_o,
    output logic lock_data_o,
    output logic ready_o
);

    logic [N_STATUS-1:0] stat_s;
    logic pll_s, sd_s, fl_s, fe_s;
    logic link_ok;
    rxrs_state_e state, state_nx;
    logic ltr_done, ltd_done, stab_done, pulse_done;

    rxrs_sync #(.W(N_STATUS), .STAGES(2)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  ({fifo_err_i, freq_lock_i, sig_det_i, pll_locked_i}),
        .dout_o (stat_s)
    );

    assign pll_s   = stat_s[0];
    assign sd_s    = stat_s[1];
    assign fl_s    = stat_s[2];
    assign fe_s    = stat_s[3];
    assign link_ok = pll_s && sd_s;

    rxrs_timer #(.LIMIT(LTR_CYCLES)) ltr_tmr_i (
        .clk(clk), .rst_n(rst_n), .run_i(state == ST_LTR), .done_o(ltr_done)
    );

    rxrs_timer #(.LIMIT(LTD_CYCLES)) ltd_tmr_i (
        .clk(clk), .rst_n(rst_n), .run_i(state == ST_LTD), .done_o(ltd_done)
    );

    rxrs_timer #(.LIMIT(STABLE_CYCLES)) stab_tmr_i (
        .clk(clk), .rst_n(rst_n), .run_i((state == ST_AWAIT) && fl_s), .done_o(stab_done)
    );

    rxrs_timer #(.LIMIT(PULSE_LEN)) pulse_tmr_i (
        .clk(clk), .rst_n(rst_n), .run_i(state == ST_PULSE), .done_o(pulse_done)
    );

    // Next-phase decision; loss of link overrides every other event
    always_comb begin
        state_nx = state;
        if (!link_ok) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = auto_mode_i ? ST_AWAIT : ST_LTR;
                ST_LTR:   if (ltr_done) state_nx = ST_LTD;
                ST_LTD:   if (ltd_done) state_nx = ST_RUN;
                ST_RUN: begin
                    if (fe_s)                     state_nx = ST_PULSE;
                    else if (auto_mode_i && !fl_s) state_nx = ST_AWAIT;
                end
                ST_AWAIT: if (stab_done) state_nx = ST_RUN;
                ST_PULSE: if (pulse_done)
                              state_nx = (auto_mode_i && !fl_s) ? ST_AWAIT : ST_RUN;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output decode from the phase register and synchronised status
    always_comb begin
        rx_digital_rst_o = (state != ST_RUN);
        lock_ref_o  = !auto_mode_i && ((state == ST_IDLE) || (state == ST_LTR));
        lock_data_o = !auto_mode_i && ((state == ST_LTD) || (state == ST_RUN) ||
                                       (state == ST_PULSE));
        ready_o     = (state == ST_RUN) && link_ok && (!auto_mode_i || fl_s);
    end

endmodule

// File: rtl/rxrs_checker.sv
// Property checker for rx_reset_seq, attached by bind below.
// Assumes: the synchronised status nets and phase of the top are visible.
module rxrs_checker
    import rxrs_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        auto_mode_i,
    input logic        pll_s,
    input logic        sd_s,
    input logic        fl_s,
    input logic        fe_s,
    input rxrs_state_e state,
    input logic        rx_digital_rst_o,
    input logic        lock_ref_o,
    input logic        lock_data_o,
    input logic        ready_o
);

    p_ctrl_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_ref_o && lock_data_o));

    p_switch_same_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_ref_o) |-> lock_data_o);

    p_release_on_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rx_digital_rst_o) && !auto_mode_i) |-> lock_data_o);

    p_pll_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_s |=> (rx_digital_rst_o && !lock_data_o && !ready_o));

    p_sig_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_s |=> (rx_digital_rst_o && !lock_data_o && !ready_o));

    p_auto_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        auto_mode_i |-> (!lock_ref_o && !lock_data_o));

    p_auto_nolock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode_i && !fl_s) |=> rx_digital_rst_o);

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && fe_s && pll_s && sd_s) |=> rx_digital_rst_o ##1 rx_digital_rst_o);

    p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!rx_digital_rst_o && pll_s && sd_s));

endmodule

bind rx_reset_seq rxrs_checker chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .auto_mode_i      (auto_mode_i),
    .pll_s            (pll_s),
    .sd_s             (sd_s),
    .fl_s             (fl_s),
    .fe_s             (fe_s),
    .state            (state),
    .rx_digital_rst_o (rx_digital_rst_o),
    .lock_ref_o       (lock_ref_o),
    .lock_data_o      (lock_data_o),
    .ready_o          (ready_o)
);

// File: tb/rx_reset_seq_tb_top.sv
// Bench for rx_reset_seq: a behavioural phase model, compared on every clock,
// plus directed checks at the points named by the requirements.
module rx_reset_seq_tb_top;

    localparam int T_LTR = 6;
    localparam int T_LTD = 4;
    localparam int T_ST  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_mode = 1'b0;
    logic pll = 1'b0, sd = 1'b0, fl = 1'b0, fe = 1'b0;
    logic rst_o, ltr_o, ltd_o, rdy_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // model state: 0 idle, 1 ref, 2 data, 3 run, 4 await, 5 pulse
    int ph = 0;
    int cnt = 0;
    logic [3:0] d1 = '0, d2 = '0;   // bench's own two-cycle delay {fe,fl,sd,pll}

    always #4 clk = ~clk;   // 125 MHz

    rx_reset_seq #(.LTR_CYCLES(T_LTR), .LTD_CYCLES(T_LTD), .STABLE_CYCLES(T_ST)) dut_i (
        .clk(clk), .rst_n(rst_n), .auto_mode_i(auto_mode),
        .pll_locked_i(pll), .sig_det_i(sd), .freq_lock_i(fl), .fifo_err_i(fe),
        .rx_digital_rst_o(rst_o), .lock_ref_o(ltr_o), .lock_data_o(ltd_o), .ready_o(rdy_o)
    );

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Reference model, advanced on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            ph = 0; cnt = 0; d1 = '0; d2 = '0;
        end else begin
            if (!(d2[0] && d2[1])) begin
                ph = 0; cnt = 0;
            end else begin
                case (ph)
                    0: begin ph = auto_mode ? 4 : 1; cnt = 0; end
                    1: begin cnt++; if (cnt == T_LTR) begin ph = 2; cnt = 0; end end
                    2: begin cnt++; if (cnt == T_LTD) begin ph = 3; cnt = 0; end end
                    3: begin
                        if (d2[3]) begin ph = 5; cnt = 0; end
                        else if (auto_mode && !d2[2]) begin ph = 4; cnt = 0; end
                    end
                    4: begin
                        if (!d2[2]) cnt = 0;
                        else begin cnt++; if (cnt == T_ST) begin ph = 3; cnt = 0; end end
                    end
                    default: begin
                        cnt++;
                        if (cnt == 2) begin ph = (auto_mode && !d2[2]) ? 4 : 3; cnt = 0; end
                    end
                endcase
            end
            d2 = d1;
            d1 = {fe, fl, sd, pll};
        end
    end

    // Compare every output on the falling edge (R2 timing is implied by the model)
    always @(negedge clk) begin
        if (cycles > 0) begin
            chk(cur_req, rst_o, ph != 3, "rx_digital_rst_o");
            chk(cur_req, ltr_o, !auto_mode && (ph <= 1), "lock_ref_o");
            chk(cur_req, ltd_o, !auto_mode && (ph == 2 || ph == 3 || ph == 5), "lock_data_o");
            chk(cur_req, rdy_o, (ph == 3) && d2[0] && d2[1] && (!auto_mode || d2[2]), "ready_o");
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count reset-high cycles over a window after an error strobe (R9)
    task automatic err_pulse(input string req);
        int highs = 0;
        @(negedge clk); fe = 1'b1;
        @(negedge clk); fe = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (rst_o) highs++;
        end
        checks++;
        if (highs != 2) begin
            errors++;
            $display("FAIL %s reset pulse width: actual %0d expected 2", req, highs);
        end
    endtask

    initial begin
        // R1: reset state, manual mode
        cur_req = "R1";
        wait_cyc(4);
        chk("R1", rst_o, 1'b1, "reset digital rst");
        chk("R1", ltr_o, 1'b1, "reset lock_ref");
        chk("R1", ltd_o, 1'b0, "reset lock_data");
        chk("R1", rdy_o, 1'b0, "reset ready");
        rst_n = 1'b1;
        wait_cyc(3);

        // R3/R4: manual bring-up
        cur_req = "R3";
        pll = 1'b1; sd = 1'b1;
        wait_cyc(3 + T_LTR);
        chk("R3", ltr_o, 1'b0, "lock_ref dropped after interval");
        chk("R3", ltd_o, 1'b1, "lock_data raised");
        cur_req = "R4";
        wait_cyc(T_LTD);
        chk("R4", rst_o, 1'b0, "released after data interval");
        chk("R10", rdy_o, 1'b1, "ready after release");

        // R9: error pulse in manual mode
        cur_req = "R9";
        err_pulse("R9");
        chk("R9", rst_o, 1'b0, "released after pulse");

        // R6: signal loss and return
        cur_req = "R6";
        sd = 1'b0;
        wait_cyc(3);
        chk("R6", rst_o, 1'b1, "reset on signal loss");
        chk("R6", ltr_o, 1'b1, "back on reference");
        chk("R10", rdy_o, 1'b0, "not ready on signal loss");
        sd = 1'b1;
        wait_cyc(T_LTR + T_LTD + 6);
        chk("R6", rst_o, 1'b0, "released after signal returns");

        // R5: single-cycle PLL loss, then a longer loss mid-sequence
        cur_req = "R5";
        pll = 1'b0; wait_cyc(1); pll = 1'b1;
        wait_cyc(3);
        chk("R5", ltr_o, 1'b1, "restart on PLL loss");
        wait_cyc(T_LTR - 2);
        pll = 1'b0;
        wait_cyc(10);
        chk("R5", ltr_o, 1'b1, "held on reference while PLL lost");
        chk("R5", rst_o, 1'b1, "reset held while PLL lost");
        pll = 1'b1;
        wait_cyc(T_LTR + T_LTD + 6);
        chk("R5", rdy_o, 1'b1, "ready after PLL returns");

        // R7/R8: automatic mode
        rst_n = 1'b0; auto_mode = 1'b1; pll = 1'b0; sd = 1'b0; fl = 1'b0;
        cur_req = "R1";
        wait_cyc(3);
        chk("R1", ltr_o, 1'b0, "auto reset lock_ref");
        rst_n = 1'b1;
        pll = 1'b1; sd = 1'b1;
        cur_req = "R7";
        wait_cyc(10);
        chk("R7", rst_o, 1'b1, "reset held without frequency lock");
        chk("R7", ltr_o | ltd_o, 1'b0, "lock controls idle");
        cur_req = "R8";
        fl = 1'b1; wait_cyc(T_ST - 1); fl = 1'b0;
        wait_cyc(6);
        chk("R8", rst_o, 1'b1, "short lock run does not release");
        fl = 1'b1;
        wait_cyc(T_ST + 4);
        chk("R8", rst_o, 1'b0, "released after stable run");
        fl = 1'b0; wait_cyc(1); fl = 1'b1;
        wait_cyc(3);
        chk("R8", rst_o, 1'b1, "re-asserted on lock drop");
        wait_cyc(T_ST + 3);
        chk("R8", rst_o, 1'b0, "released again");
        cur_req = "R9";
        err_pulse("R9");
        cur_req = "R2";
        wait_cyc(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        wait_cyc(100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule